// File: doc/BRIEF.md
# Shader Program Memory Loader

This block sits on a chip's register-write path and turns a plain stream of register writes into the setup state of two shader units, called unit A and unit B. For each unit it keeps a program store and an operand-descriptor (swizzle) store. Each store has its own write cursor. Software points the cursor at a slot by writing the cursor's set register. It then streams words to any one of eight interchangeable data addresses. Each accepted word lands at the cursor, and the cursor then moves on by one. A word that would land at or past the end of its store is discarded and the cursor stays where it is. For the program stores, such a discard also raises a sticky error flag.

The same decoder also unpacks a 16-bit boolean-constant word into separate flags and captures four 32-bit integer-constant words per unit. Each integer word carries four 8-bit components. Every store has a synchronous read port for the execution side. The write side is a single-cycle strobe with no back-pressure: every strobe is taken in the cycle it appears. Addresses that the block does not own are ignored.

Top module: `loader_top`

## Requirements
- R1: A write to any of the eight aliased program-data addresses (unit B 0x29c–0x2a3, unit A 0x2cc–0x2d3) stores the data word at the unit's program cursor and then advances that cursor by one.
- R2: A write to any of the eight aliased swizzle-data addresses (unit B 0x2a6–0x2ad, unit A 0x2d6–0x2dd) stores the word at the unit's swizzle cursor and then advances that cursor by one.
- R3: Writing a cursor set register (program: unit B 0x29b, unit A 0x2cb; swizzle: unit B 0x2a5, unit A 0x2d5) loads the low bits of the data word into that cursor. The next data word lands at that slot.
- R4: Unit A's program store takes cursor values below PROG_DEPTH_A (default 512). A program write at or beyond that value stores nothing, leaves the cursor unchanged, and sets a_prog_err. a_prog_err then stays set until reset.
- R5: Unit B's program store takes cursor values below PROG_DEPTH_B (default 1024). Writes at or beyond that value behave as in R4 and set b_prog_err.
- R6: A swizzle write at a cursor of SWZ_DEPTH (default 512) or more stores nothing, leaves the cursor unchanged and raises no error.
- R7: A write to the boolean register (unit B 0x280, unit A 0x2b0) sets flag i equal to bit i of the data word, for i from 0 to 15.
- R8: The integer-constant registers sit at unit B 0x281–0x284 and unit A 0x2b1–0x2b4. The index is the address minus the first of these. The word written at index k appears on bits 32k+31 down to 32k of the unit's ints output.
- R9: Each read port returns the word at its address one cycle after the address is presented. A read of the slot being written in the same cycle returns the word that was there before.
- R10: With wr_valid low, or with an address the block does not own, no cursor, flag, error or constant changes.
- R11: Synchronous reset clears all cursors, boolean flags, integer constants and error flags. Store contents are kept.
- R12: A write to one unit's address changes none of the other unit's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Register-write strobe, one cycle per write |
| wr_addr | input | 10 | Register address |
| wr_data | input | 32 | Register data |
| a_bool | output | 16 | Unit A boolean flags |
| a_ints | output | 128 | Unit A integer constants, index k at bits 32k+31:32k |
| a_prog_ofs | output | 10 | Unit A program cursor |
| a_swz_ofs | output | 10 | Unit A swizzle cursor |
| a_prog_err | output | 1 | Unit A sticky program-overflow flag |
| a_prog_raddr | input | 9 | Unit A program read address |
| a_prog_rdata | output | 32 | Unit A program read data |
| a_swz_raddr | input | 9 | Unit A swizzle read address |
| a_swz_rdata | output | 32 | Unit A swizzle read data |
| b_bool | output | 16 | Unit B boolean flags |
| b_ints | output | 128 | Unit B integer constants |
| b_prog_ofs | output | 11 | Unit B program cursor |
| b_swz_ofs | output | 10 | Unit B swizzle cursor |
| b_prog_err | output | 1 | Unit B sticky program-overflow flag |
| b_prog_raddr | input | 10 | Unit B program read address |
| b_prog_rdata | output | 32 | Unit B program read data |
| b_swz_raddr | input | 9 | Unit B swizzle read address |
| b_swz_rdata | output | 32 | Unit B swizzle read data |

## Verification
A program store can be read and written in the same cycle. The case that matters is a read aimed at the very slot the cursor is filling. To provoke it, the bench moves the cursor back onto a slot that already holds a word. It then issues a new data write while the read address points at that slot. The read data one cycle later must still show the earlier word, and a second read must show the new one. A cursor set register and a data write can never share a cycle, since there is one address per strobe. The bench instead runs a set and a data write back to back at the end of each store, to check that the set is honoured and the drop rule applies.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int ALIAS_N = 8;
  localparam int INT_N   = 4;
  localparam int BOOL_N  = 16;

  // positions relative to a unit's base address
  localparam int REL_BOOL = 0;
  localparam int REL_INT  = 1;
  localparam int REL_PSET = 27;
  localparam int REL_PDAT = 28;
  localparam int REL_SSET = 37;
  localparam int REL_SDAT = 38;

  typedef enum logic [2:0] {
    K_NONE, K_BOOL, K_INT, K_PSET, K_PDAT, K_SSET, K_SDAT
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] idx;
  } dec_t;
endpackage

// File: rtl/loader_decode.sv
module loader_decode
  import loader_pkg::*;
#(
  parameter int BASE = 'h2b0
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel      = addr - ADDR_W'(BASE);
    dec.kind = K_NONE;
    dec.idx  = '0;
    if (valid && addr >= ADDR_W'(BASE)) begin
      if (rel == ADDR_W'(REL_BOOL)) begin
        dec.kind = K_BOOL;
      end else if (rel >= ADDR_W'(REL_INT) && rel < ADDR_W'(REL_INT + INT_N)) begin
        dec.kind = K_INT;
        dec.idx  = 2'(rel - ADDR_W'(REL_INT));
      end else if (rel == ADDR_W'(REL_PSET)) begin
        dec.kind = K_PSET;
      end else if (rel >= ADDR_W'(REL_PDAT) && rel < ADDR_W'(REL_PDAT + ALIAS_N)) begin
        dec.kind = K_PDAT;
      end else if (rel == ADDR_W'(REL_SSET)) begin
        dec.kind = K_SSET;
      end else if (rel >= ADDR_W'(REL_SDAT) && rel < ADDR_W'(REL_SDAT + ALIAS_N)) begin
        dec.kind = K_SDAT;
      end
    end
  end
endmodule

// File: rtl/loader_cursor.sv
module loader_cursor #(
  parameter int LIMIT = 512,
  localparam int CW   = $clog2(LIMIT) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic [CW-1:0] set_val,
  input  logic          push,
  output logic [CW-1:0] ofs,
  output logic          store_en,
  output logic          reject
);
  logic in_range;

  assign in_range = ofs < CW'(LIMIT);
  assign store_en = push && in_range;
  assign reject   = push && !in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs <= '0;
    end else if (set) begin
      ofs <= set_val;
    end else if (store_en) begin
      ofs <= ofs + CW'(1);
    end
  end
endmodule

// File: rtl/loader_store.sv
module loader_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/loader_unit.sv
module loader_unit
  import loader_pkg::*;
#(
  parameter int BASE       = 'h2b0,
  parameter int PROG_DEPTH = 512,
  parameter int SWZ_DEPTH  = 512,
  localparam int PCW = $clog2(PROG_DEPTH) + 1,
  localparam int SCW = $clog2(SWZ_DEPTH) + 1,
  localparam int PAW = $clog2(PROG_DEPTH),
  localparam int SAW = $clog2(SWZ_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [BOOL_N-1:0]       bool_flags,
  output logic [INT_N*DATA_W-1:0] int_words,
  output logic [PCW-1:0]          prog_ofs,
  output logic [SCW-1:0]          swz_ofs,
  output logic                    prog_err,
  input  logic [PAW-1:0]          prog_raddr,
  output logic [DATA_W-1:0]       prog_rdata,
  input  logic [SAW-1:0]          swz_raddr,
  output logic [DATA_W-1:0]       swz_rdata
);
  dec_t              dec;
  logic              p_store, p_reject, s_store, s_reject;
  logic [DATA_W-1:0] int_q [INT_N];

  loader_decode #(.BASE(BASE)) u_dec (
    .valid(wr_valid), .addr(wr_addr), .dec(dec)
  );

  loader_cursor #(.LIMIT(PROG_DEPTH)) u_pcur (
    .clk(clk), .rst(rst),
    .set(dec.kind == K_PSET), .set_val(wr_data[PCW-1:0]),
    .push(dec.kind == K_PDAT),
    .ofs(prog_ofs), .store_en(p_store), .reject(p_reject)
  );

  loader_cursor #(.LIMIT(SWZ_DEPTH)) u_scur (
    .clk(clk), .rst(rst),
    .set(dec.kind == K_SSET), .set_val(wr_data[SCW-1:0]),
    .push(dec.kind == K_SDAT),
    .ofs(swz_ofs), .store_en(s_store), .reject(s_reject)
  );

  loader_store #(.DEPTH(PROG_DEPTH), .DW(DATA_W)) u_pmem (
    .clk(clk), .we(p_store), .waddr(prog_ofs[PAW-1:0]), .wdata(wr_data),
    .raddr(prog_raddr), .rdata(prog_rdata)
  );

  loader_store #(.DEPTH(SWZ_DEPTH), .DW(DATA_W)) u_smem (
    .clk(clk), .we(s_store), .waddr(swz_ofs[SAW-1:0]), .wdata(wr_data),
    .raddr(swz_raddr), .rdata(swz_rdata)
  );

  // sticky overflow flag for the program store; swizzle drops stay silent
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_err <= 1'b0;
    end else if (p_reject) begin
      prog_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bool_flags <= '0;
    end else if (dec.kind == K_BOOL) begin
      bool_flags <= wr_data[BOOL_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < INT_N; i++) begin
      if (rst) begin
        int_q[i] <= '0;
      end else if (dec.kind == K_INT && dec.idx == 2'(i)) begin
        int_q[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < INT_N; g++) begin : g_pack
    assign int_words[g*DATA_W +: DATA_W] = int_q[g];
  end

  logic unused_ok;
  assign unused_ok = s_reject;
endmodule

// File: rtl/loader_top.sv
module loader_top
  import loader_pkg::*;
#(
  parameter int PROG_DEPTH_A = 512,
  parameter int PROG_DEPTH_B = 1024,
  parameter int SWZ_DEPTH    = 512,
  parameter int BASE_A       = 'h2b0,
  parameter int BASE_B       = 'h280
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_valid,
  input  logic [9:0]                      wr_addr,
  input  logic [31:0]                     wr_data,
  output logic [15:0]                     a_bool,
  output logic [127:0]                    a_ints,
  output logic [$clog2(PROG_DEPTH_A):0]   a_prog_ofs,
  output logic [$clog2(SWZ_DEPTH):0]      a_swz_ofs,
  output logic                            a_prog_err,
  input  logic [$clog2(PROG_DEPTH_A)-1:0] a_prog_raddr,
  output logic [31:0]                     a_prog_rdata,
  input  logic [$clog2(SWZ_DEPTH)-1:0]    a_swz_raddr,
  output logic [31:0]                     a_swz_rdata,
  output logic [15:0]                     b_bool,
  output logic [127:0]                    b_ints,
  output logic [$clog2(PROG_DEPTH_B):0]   b_prog_ofs,
  output logic [$clog2(SWZ_DEPTH):0]      b_swz_ofs,
  output logic                            b_prog_err,
  input  logic [$clog2(PROG_DEPTH_B)-1:0] b_prog_raddr,
  output logic [31:0]                     b_prog_rdata,
  input  logic [$clog2(SWZ_DEPTH)-1:0]    b_swz_raddr,
  output logic [31:0]                     b_swz_rdata
);
  loader_unit #(.BASE(BASE_A), .PROG_DEPTH(PROG_DEPTH_A), .SWZ_DEPTH(SWZ_DEPTH)) u_unit_a (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .bool_flags(a_bool), .int_words(a_ints), .prog_ofs(a_prog_ofs), .swz_ofs(a_swz_ofs),
    .prog_err(a_prog_err), .prog_raddr(a_prog_raddr), .prog_rdata(a_prog_rdata),
    .swz_raddr(a_swz_raddr), .swz_rdata(a_swz_rdata)
  );

  loader_unit #(.BASE(BASE_B), .PROG_DEPTH(PROG_DEPTH_B), .SWZ_DEPTH(SWZ_DEPTH)) u_unit_b (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .bool_flags(b_bool), .int_words(b_ints), .prog_ofs(b_prog_ofs), .swz_ofs(b_swz_ofs),
    .prog_err(b_prog_err), .prog_raddr(b_prog_raddr), .prog_rdata(b_prog_rdata),
    .swz_raddr(b_swz_raddr), .swz_rdata(b_swz_rdata)
  );
endmodule

// File: rtl/loader_chk.sv
module loader_chk
  import loader_pkg::*;
#(
  parameter int PROG_DEPTH_A = 512,
  parameter int PROG_DEPTH_B = 1024,
  parameter int SWZ_DEPTH    = 512,
  parameter int BASE_A       = 'h2b0,
  parameter int BASE_B       = 'h280
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_valid,
  input logic [9:0]                    wr_addr,
  input logic [15:0]                   a_bool,
  input logic [$clog2(PROG_DEPTH_A):0] a_prog_ofs,
  input logic [$clog2(SWZ_DEPTH):0]    a_swz_ofs,
  input logic                          a_prog_err,
  input logic [$clog2(PROG_DEPTH_B):0] b_prog_ofs,
  input logic [$clog2(SWZ_DEPTH):0]    b_swz_ofs,
  input logic                          b_prog_err
);
  localparam int A_PD = BASE_A + REL_PDAT;
  localparam int B_PD = BASE_B + REL_PDAT;
  localparam int B_SD = BASE_B + REL_SDAT;

  logic a_pd_hit, b_pd_hit, b_sd_hit;
  assign a_pd_hit = wr_valid && int'(wr_addr) >= A_PD && int'(wr_addr) < A_PD + ALIAS_N;
  assign b_pd_hit = wr_valid && int'(wr_addr) >= B_PD && int'(wr_addr) < B_PD + ALIAS_N;
  assign b_sd_hit = wr_valid && int'(wr_addr) >= B_SD && int'(wr_addr) < B_SD + ALIAS_N;

  a_r1_prog_step: assert property (@(posedge clk) disable iff (rst)
    (a_pd_hit && int'(a_prog_ofs) < PROG_DEPTH_A) |=> int'(a_prog_ofs) == int'($past(a_prog_ofs)) + 1);

  a_r4_drop_hold: assert property (@(posedge clk) disable iff (rst)
    (a_pd_hit && int'(a_prog_ofs) >= PROG_DEPTH_A) |=> ($stable(a_prog_ofs) && a_prog_err));

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    a_prog_err |=> a_prog_err);

  a_r5_drop_hold: assert property (@(posedge clk) disable iff (rst)
    (b_pd_hit && int'(b_prog_ofs) >= PROG_DEPTH_B) |=> ($stable(b_prog_ofs) && b_prog_err));

  a_r6_swz_hold: assert property (@(posedge clk) disable iff (rst)
    (b_sd_hit && int'(b_swz_ofs) >= SWZ_DEPTH) |=> $stable(b_swz_ofs));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> ($stable(a_prog_ofs) && $stable(b_prog_ofs) && $stable(a_swz_ofs)
                   && $stable(b_swz_ofs) && $stable(a_bool)));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (a_prog_ofs == '0 && b_prog_ofs == '0 && a_swz_ofs == '0 && b_swz_ofs == '0
             && !a_prog_err && !b_prog_err && a_bool == '0));
endmodule

bind loader_top loader_chk #(
  .PROG_DEPTH_A(PROG_DEPTH_A), .PROG_DEPTH_B(PROG_DEPTH_B), .SWZ_DEPTH(SWZ_DEPTH),
  .BASE_A(BASE_A), .BASE_B(BASE_B)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .a_bool(a_bool),
  .a_prog_ofs(a_prog_ofs), .a_swz_ofs(a_swz_ofs), .a_prog_err(a_prog_err),
  .b_prog_ofs(b_prog_ofs), .b_swz_ofs(b_swz_ofs), .b_prog_err(b_prog_err)
);

// File: tb/loader_top_tb.sv
module loader_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic [9:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [15:0]  a_bool, b_bool;
  logic [127:0] a_ints, b_ints;
  logic [9:0]   a_prog_ofs, a_swz_ofs, b_swz_ofs;
  logic [10:0]  b_prog_ofs;
  logic         a_prog_err, b_prog_err;
  logic [8:0]   a_prog_raddr = '0, a_swz_raddr = '0, b_swz_raddr = '0;
  logic [9:0]   b_prog_raddr = '0;
  logic [31:0]  a_prog_rdata, a_swz_rdata, b_prog_rdata, b_swz_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  loader_top u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .a_bool(a_bool), .a_ints(a_ints), .a_prog_ofs(a_prog_ofs), .a_swz_ofs(a_swz_ofs),
    .a_prog_err(a_prog_err), .a_prog_raddr(a_prog_raddr), .a_prog_rdata(a_prog_rdata),
    .a_swz_raddr(a_swz_raddr), .a_swz_rdata(a_swz_rdata),
    .b_bool(b_bool), .b_ints(b_ints), .b_prog_ofs(b_prog_ofs), .b_swz_ofs(b_swz_ofs),
    .b_prog_err(b_prog_err), .b_prog_raddr(b_prog_raddr), .b_prog_rdata(b_prog_rdata),
    .b_swz_raddr(b_swz_raddr), .b_swz_rdata(b_swz_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // mem: 0 A prog, 1 A swz, 2 B prog, 3 B swz
  task automatic rd(input int mem, input int a, output logic [31:0] d);
    @(negedge clk);
    case (mem)
      0: a_prog_raddr = 9'(a);
      1: a_swz_raddr  = 9'(a);
      2: b_prog_raddr = 10'(a);
      default: b_swz_raddr = 9'(a);
    endcase
    @(negedge clk);
    case (mem)
      0: d = a_prog_rdata;
      1: d = a_swz_rdata;
      2: d = b_prog_rdata;
      default: d = b_swz_rdata;
    endcase
  endtask

  function automatic logic [31:0] obs(input int sel);
    case (sel)
      0: return 32'(a_prog_ofs);
      1: return 32'(a_swz_ofs);
      2: return 32'(b_prog_ofs);
      3: return 32'(b_swz_ofs);
      4: return 32'(a_bool);
      default: return 32'(b_bool);
    endcase
  endfunction

  // fields: req[81:78] sel[77:74] addr[73:64] data[63:32] expected[31:0]
  localparam int NV = 14;
  localparam logic [81:0] VEC [NV] = '{
    {4'd3,  4'd0, 10'h2cb, 32'd5,        32'd5},      // R3 set A program cursor
    {4'd1,  4'd0, 10'h2cc, 32'h11111111, 32'd6},      // R1 first alias
    {4'd1,  4'd0, 10'h2d3, 32'h22222222, 32'd7},      // R1 last alias
    {4'd1,  4'd0, 10'h2cf, 32'h00000033, 32'd8},      // R1 middle alias
    {4'd1,  4'd2, 10'h29c, 32'h000000b0, 32'd1},      // R1 unit B
    {4'd1,  4'd2, 10'h2a3, 32'h000000b1, 32'd2},      // R1 unit B
    {4'd2,  4'd1, 10'h2d6, 32'h0000005a, 32'd1},      // R2 unit A swizzle
    {4'd2,  4'd3, 10'h2ad, 32'h0000006b, 32'd1},      // R2 unit B swizzle
    {4'd7,  4'd4, 10'h2b0, 32'hffff8001, 32'h8001},   // R7 unit A flags
    {4'd7,  4'd5, 10'h280, 32'h00005aa5, 32'h5aa5},   // R7 unit B flags
    {4'd10, 4'd0, 10'h2d4, 32'h12345678, 32'd8},      // R10 hole in map
    {4'd10, 4'd1, 10'h3ff, 32'h12345678, 32'd1},      // R10 top address
    {4'd10, 4'd2, 10'h2a4, 32'h12345678, 32'd2},      // R10 hole in map
    {4'd3,  4'd3, 10'h2a5, 32'd3,        32'd3}       // R3 set B swizzle cursor
  };

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 a_prog_ofs", 32'(a_prog_ofs), 0);
    check("R11 b_prog_ofs", 32'(b_prog_ofs), 0);
    check("R11 errs", {30'd0, a_prog_err, b_prog_err}, 0);
    check("R11 bools", {a_bool, b_bool}, 0);
    check("R11 ints", a_ints[31:0] | b_ints[127:96], 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      check($sformatf("R%0d vec%0d", VEC[i][81:78], i), obs(int'(VEC[i][77:74])), VEC[i][31:0]);
    end

    rd(0, 5, v); check("R1 A prog[5]", v, 32'h11111111);
    rd(0, 6, v); check("R1 A prog[6]", v, 32'h22222222);
    rd(0, 7, v); check("R9 A prog[7]", v, 32'h33);
    rd(2, 0, v); check("R1 B prog[0]", v, 32'hb0);
    rd(2, 1, v); check("R1 B prog[1]", v, 32'hb1);
    rd(1, 0, v); check("R2 A swz[0]", v, 32'h5a);
    rd(3, 0, v); check("R2 B swz[0]", v, 32'h6b);

    wr(10'h2a6, 32'h77);
    check("R3 B swz cursor", 32'(b_swz_ofs), 4);
    rd(3, 3, v); check("R3 B swz[3]", v, 32'h77);

    wr(10'h2b3, 32'hdeadbeef);
    check("R8 A int2", a_ints[95:64], 32'hdeadbeef);
    check("R8 A int0", a_ints[31:0], 0);
    wr(10'h284, 32'h01020304);
    check("R8 B int3", b_ints[127:96], 32'h01020304);
    check("R12 A int3", a_ints[127:96], 0);
    check("R12 A flags", 32'(a_bool), 32'h8001);

    // R9 read of the slot being written in the same cycle
    wr(10'h2cc, 32'h44);
    wr(10'h2cb, 32'd8);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 10'h2cd; wr_data = 32'h55; a_prog_raddr = 9'd8;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R9 old word", a_prog_rdata, 32'h44);
    rd(0, 8, v); check("R9 new word", v, 32'h55);

    // R4 end of unit A program store
    wr(10'h2cb, 32'd511);
    wr(10'h2d0, 32'haa);
    check("R4 cursor at limit", 32'(a_prog_ofs), 512);
    check("R4 no err yet", 32'(a_prog_err), 0);
    wr(10'h2d1, 32'hbb);
    check("R4 cursor held", 32'(a_prog_ofs), 512);
    check("R4 err set", 32'(a_prog_err), 1);
    rd(0, 511, v); check("R4 last slot", v, 32'haa);
    wr(10'h2cb, 32'd0);
    wr(10'h2cc, 32'h1);
    check("R4 err sticky", 32'(a_prog_err), 1);
    check("R12 B err clear", 32'(b_prog_err), 0);

    // R5 end of unit B program store
    wr(10'h29b, 32'd1023);
    wr(10'h29d, 32'hcc);
    check("R5 cursor at limit", 32'(b_prog_ofs), 1024);
    wr(10'h29e, 32'hdd);
    check("R5 cursor held", 32'(b_prog_ofs), 1024);
    check("R5 err set", 32'(b_prog_err), 1);
    rd(2, 1023, v); check("R5 last slot", v, 32'hcc);

    // R6 end of swizzle store
    wr(10'h2d5, 32'd511);
    wr(10'h2d7, 32'he1);
    check("R6 cursor at limit", 32'(a_swz_ofs), 512);
    wr(10'h2d8, 32'he2);
    check("R6 cursor held", 32'(a_swz_ofs), 512);
    rd(1, 511, v); check("R6 last slot", v, 32'he1);

    // R10 strobe low
    @(negedge clk);
    wr_addr = 10'h2cc; wr_data = 32'h99; wr_valid = 1'b0;
    @(negedge clk);
    check("R10 strobe low", 32'(a_prog_ofs), 1);

    // R11 reset mid-run keeps contents
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11 cursors", 32'(a_prog_ofs) | 32'(b_prog_ofs) | 32'(a_swz_ofs) | 32'(b_swz_ofs), 0);
    check("R11 errs", {30'd0, a_prog_err, b_prog_err}, 0);
    check("R11 flags", {a_bool, b_bool}, 0);
    check("R11 ints", a_ints[95:64] | b_ints[127:96], 0);
    rd(0, 5, v); check("R11 contents kept", v, 32'h11111111);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule